// File: doc/BRIEF.md
# Compare-Based Watchdog Counter

The block is a watchdog that counts prescaled ticks from one of several timing sources and raises a reset request when the count reaches a compare value that software writes. Software keeps the system alive by writing the counter, usually back to zero, before the count catches up with the compare value. A one-bit enable register starts and pauses counting, and pausing keeps the count.

Four 32-bit words sit on a single-cycle register port: compare, enable, counter and control. Writes take effect on the clock edge that samples them. Reads are combinational from the word address. The control word picks a tick source and a power-of-four prescale. A chip-level reset generator takes the one-clock request pulse. Software brings the block up in this order: disable, write control, write the compare value, zero the counter, enable.

Top module: `wdt_cmp`

## Requirements
- R1: After reset every register reads zero and `rst_req_o` is low.
- R2: Word offsets decode on `addr_i[3:2]`: 0x0 compare, 0x4 enable, 0x8 counter, 0xC control. Compare and counter hold CNT_W=16 bits, enable holds bit 0, control holds bits 5:0. All other bits read as zero.
- R3: Enable bit 0 at 1 lets the counter advance. Writing 0 pauses the counter and keeps its value. Writing 1 again resumes from that value.
- R4: A write to the counter loads `wdata_i[15:0]` on that edge at any time. It wins over a tick on the same edge.
- R5: Control bits 2:0 select the source. Code 0 selects nothing. Code k in 1..NUM_SRC (3) selects `src_tick_i[k-1]`. Codes above NUM_SRC select nothing. With no source selected, the counter does not move.
- R6: Control bits 5:3 hold prescale code c. For c from 0 to 5 the counter advances once per 4^c selected ticks. Codes 6 and 7 act like code 5. The counter never moves by more than one per clock.
- R7: While enabled and not halted, a counter equal to compare drives `rst_req_o` high for exactly one clock, starting at the next edge.
- R8: After a request the counter freezes and no further request follows. This lasts until the counter is written or the enable register is written with bit 0 set.
- R9: A write to the counter or to the control word restarts the prescale phase.
- R10: Writing the counter back to zero before it reaches compare prevents any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Byte address of the register word |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i` |
| src_tick_i | input | NUM_SRC (3) | One-clock tick strobes, one per source |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
The bench keeps the default parameters: a 16-bit counter, three tick sources and a top prescale code of 5. With a divide of at most 1024, the largest prescale code can be reached a few times over within the cycle budget. With three sources, codes 4 to 7 remain outside the source range, so the no-source path is tested with a real code and not only code 0. Compare values of 3 and 4 bring the request, the freeze, the release by re-enable and the rescue by a counter write within a handful of ticks.

// File: rtl/wdt_cmp_pkg.sv
package wdt_cmp_pkg;
  // word index = addr[3:2]; order is the software-visible map
  typedef enum logic [1:0] {
    REG_CMP = 2'd0,
    REG_ENA = 2'd1,
    REG_CNT = 2'd2,
    REG_CTL = 2'd3
  } reg_idx_e;

  localparam int unsigned FLD_W = 3;

  typedef struct packed {
    logic [FLD_W-1:0] pre;  // bits 5:3
    logic [FLD_W-1:0] src;  // bits 2:0
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/wdt_cmp_regs.sv
module wdt_cmp_regs
  import wdt_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              en_o,
  output ctl_t              ctl_o,
  output logic              cnt_wr_o,
  output logic              en_set_o,
  output logic              ctl_wr_o
);
  reg_idx_e idx;
  logic     unused_bits;

  assign idx         = reg_idx_e'(addr_i[3:2]);
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CNT_W]};

  assign cnt_wr_o = wr_en_i && (idx == REG_CNT);
  assign ctl_wr_o = wr_en_i && (idx == REG_CTL);
  assign en_set_o = wr_en_i && (idx == REG_ENA) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o <= '0;
      en_o  <= 1'b0;
      ctl_o <= '0;
    end else if (wr_en_i) begin
      unique case (idx)
        REG_CMP: cmp_o <= wdata_i[CNT_W-1:0];
        REG_ENA: en_o  <= wdata_i[0];
        REG_CTL: ctl_o <= ctl_t'(wdata_i[CTL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_CMP: rdata_o[CNT_W-1:0] = cmp_o;
      REG_ENA: rdata_o[0]         = en_o;
      REG_CNT: rdata_o[CNT_W-1:0] = cnt_i;
      REG_CTL: rdata_o[CTL_W-1:0] = ctl_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/wdt_cmp_tick.sv
module wdt_cmp_tick #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned MAX_PRE = 5,
  parameter int unsigned FLD_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [FLD_W-1:0]   src_sel_i,
  input  logic [FLD_W-1:0]   pre_sel_i,
  input  logic               run_i,
  input  logic               clear_i,
  output logic               tick_o
);
  localparam int unsigned PRE_W = 2 * MAX_PRE;

  logic             sel;
  logic [FLD_W-1:0] code_eff;
  logic [PRE_W-1:0] term;
  logic [PRE_W-1:0] pre_q;
  logic             fire;

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel_i == FLD_W'(i + 1)) sel = src_tick_i[i];
    end
  end

  assign code_eff = (pre_sel_i > FLD_W'(MAX_PRE)) ? FLD_W'(MAX_PRE) : pre_sel_i;

  // terminal count 4^code - 1: two ones per code step
  always_comb begin
    term = '0;
    for (int c = 1; c <= MAX_PRE; c++) begin
      if (int'(code_eff) >= c) term[2*c-1 -: 2] = 2'b11;
    end
  end

  assign fire   = (pre_q == term);
  assign tick_o = sel && run_i && fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (clear_i)       pre_q <= '0;
    else if (sel && run_i)  pre_q <= fire ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_cmp_core.sv
module wdt_cmp_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             en_set_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             rst_req_o
);
  logic halt_q;
  logic hit;

  assign run_o = en_i && !halt_q;
  assign hit   = run_o && (cnt_o == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      halt_q    <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= hit;
      if (cnt_wr_i) begin
        cnt_o  <= cnt_wdata_i;
        halt_q <= 1'b0;
      end else begin
        if (hit)                cnt_o <= cnt_o;
        else if (run_o && tick_i) cnt_o <= cnt_o + 1'b1;
        if (hit)                halt_q <= 1'b1;
        else if (en_set_i)      halt_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_cmp.sv
module wdt_cmp
  import wdt_cmp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned MAX_PRE = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic               rst_req_o
);
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] cnt_w;
  logic             en_w;
  ctl_t             ctl_w;
  logic             cnt_wr_w;
  logic             en_set_w;
  logic             ctl_wr_w;
  logic             run_w;
  logic             tick_w;
  logic [FLD_W-1:0] ctl_src_w;

  assign ctl_src_w = ctl_w.src;

  wdt_cmp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt_w),
    .rdata_o  (rdata_o),
    .cmp_o    (cmp_w),
    .en_o     (en_w),
    .ctl_o    (ctl_w),
    .cnt_wr_o (cnt_wr_w),
    .en_set_o (en_set_w),
    .ctl_wr_o (ctl_wr_w)
  );

  wdt_cmp_tick #(.NUM_SRC(NUM_SRC), .MAX_PRE(MAX_PRE), .FLD_W(FLD_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (src_tick_i),
    .src_sel_i  (ctl_w.src),
    .pre_sel_i  (ctl_w.pre),
    .run_i      (run_w),
    .clear_i    (cnt_wr_w || ctl_wr_w),
    .tick_o     (tick_w)
  );

  wdt_cmp_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_w),
    .cmp_i       (cmp_w),
    .tick_i      (tick_w),
    .cnt_wr_i    (cnt_wr_w),
    .cnt_wdata_i (wdata_i[CNT_W-1:0]),
    .en_set_i    (en_set_w),
    .cnt_o       (cnt_w),
    .run_o       (run_w),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: rtl/wdt_cmp_chk.sv
module wdt_cmp_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FLD_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_o,
  input logic             en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic [FLD_W-1:0] src_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] wdata_lo_i
);
  AST_REQ_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R7

  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(en_i && (cnt_i == cmp_i))); // R7

  AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_i)); // R3

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_i == $past(wdata_lo_i))); // R4

  AST_NO_SRC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i == '0) && !cnt_wr_i) |=> $stable(cnt_i)); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> ((cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1))); // R6

  AST_FROZEN_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !cnt_wr_i) |=> $stable(cnt_i)); // R8
endmodule

bind wdt_cmp wdt_cmp_chk #(.CNT_W(CNT_W), .FLD_W(wdt_cmp_pkg::FLD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_o  (rst_req_o),
  .en_i       (en_w),
  .cnt_i      (cnt_w),
  .cmp_i      (cmp_w),
  .src_i      (ctl_src_w),
  .cnt_wr_i   (cnt_wr_w),
  .wdata_lo_i (wdata_i[CNT_W-1:0])
);

// File: tb/tb_wdt_cmp.sv
`timescale 1ns/1ps
module tb_wdt_cmp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  src_tick_i = '0;
  logic        rst_req_o;

  int n_chk = 0;
  int n_err = 0;
  int req_seen = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  wdt_cmp dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_tick_i(src_tick_i),
    .rst_req_o(rst_req_o)
  );

  always @(negedge clk_i) if (rst_ni && rst_req_o) req_seen++;

  typedef struct packed {
    logic [2:0]  src;
    logic [1:0]  line;
    logic [2:0]  pre;
    logic [15:0] n;
    logic [15:0] exp;
  } vec_t;

  // R5 R6: source code, pulsed line, prescale code, pulses, expected count
  localparam vec_t VECS [11] = '{
    '{3'd1, 2'd0, 3'd0, 16'd5,    16'd5},
    '{3'd2, 2'd1, 3'd1, 16'd9,    16'd2},
    '{3'd3, 2'd2, 3'd2, 16'd33,   16'd2},
    '{3'd0, 2'd0, 3'd0, 16'd4,    16'd0},
    '{3'd1, 2'd1, 3'd0, 16'd4,    16'd0},
    '{3'd4, 2'd0, 3'd0, 16'd4,    16'd0},
    '{3'd1, 2'd0, 3'd3, 16'd130,  16'd2},
    '{3'd2, 2'd1, 3'd4, 16'd256,  16'd1},
    '{3'd3, 2'd2, 3'd5, 16'd2048, 16'd2},
    '{3'd1, 2'd0, 3'd6, 16'd1025, 16'd1},
    '{3'd1, 2'd0, 3'd7, 16'd1023, 16'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input int line);
    @(negedge clk_i);
    src_tick_i[line] = 1'b1;
    @(negedge clk_i);
    src_tick_i = '0;
  endtask

  task automatic pulses(input int line, input int n);
    for (int p = 0; p < n; p++) pulse(line);
  endtask

  // bring-up order: disable, control, compare, zero counter, enable
  task automatic cfg(input logic [2:0] src, input logic [2:0] pre, input logic [15:0] cmp);
    wr(4'h4, 32'h0);
    wr(4'hC, {26'h0, pre, src});
    wr(4'h0, {16'h0, cmp});
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 req", {31'h0, rst_req_o}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      check("R1 reg", d, 32'h0);
    end

    // R2 widths and map
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); check("R2 cmp", d, 32'h0000_FFFF);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); check("R2 ctl", d, 32'h0000_003F);
    wr(4'h4, 32'hFFFF_FFFE); rd(4'h4, d); check("R2 ena0", d, 32'h0);
    wr(4'h4, 32'h8000_0001); rd(4'h4, d); check("R2 ena1", d, 32'h1);
    wr(4'h4, 32'h0);
    // R4 load at any time, upper bits dropped
    wr(4'h8, 32'hABCD_1234); rd(4'h8, d); check("R4 load", d, 32'h0000_1234);

    // table walk: R5 R6
    for (int i = 0; i < 11; i++) begin
      cfg(VECS[i].src, VECS[i].pre, 16'hFFFF);
      pulses(int'(VECS[i].line), int'(VECS[i].n));
      rd(4'h8, d);
      check($sformatf("R5 R6 vec %0d", i), d, {16'h0, VECS[i].exp});
    end

    // R3 pause keeps count, resume continues
    cfg(3'd1, 3'd0, 16'hFFFF);
    pulses(0, 3);
    wr(4'h4, 32'h0);
    pulses(0, 3);
    rd(4'h8, d); check("R3 paused", d, 32'd3);
    wr(4'h4, 32'h1);
    pulses(0, 2);
    rd(4'h8, d); check("R3 resumed", d, 32'd5);

    // R4 write beats a tick on the same edge
    @(negedge clk_i);
    src_tick_i[0] = 1'b1; wr_en_i = 1'b1; addr_i = 4'h8; wdata_i = 32'h5555_0100;
    @(negedge clk_i);
    src_tick_i = '0; wr_en_i = 1'b0;
    rd(4'h8, d); check("R4 priority", d, 32'h0000_0100);

    // R9 prescale phase restarts on counter write
    cfg(3'd1, 3'd1, 16'hFFFF);
    pulses(0, 3);
    wr(4'h8, 32'h0);
    pulses(0, 3);
    rd(4'h8, d); check("R9 no step", d, 32'd0);
    pulse(0);
    rd(4'h8, d); check("R9 step", d, 32'd1);

    // R7 request timing
    cfg(3'd1, 3'd0, 16'd3);
    base = req_seen;
    pulses(0, 3);
    check("R7 before", {31'h0, rst_req_o}, 32'h0);
    @(negedge clk_i); check("R7 high", {31'h0, rst_req_o}, 32'h1);
    @(negedge clk_i); check("R7 low", {31'h0, rst_req_o}, 32'h0);

    // R8 frozen, no repeat request
    pulses(0, 4);
    rd(4'h8, d); check("R8 frozen", d, 32'd3);
    check("R8 single", 32'(req_seen - base), 32'd1);
    wr(4'h4, 32'h1);
    @(negedge clk_i); check("R8 reenable", {31'h0, rst_req_o}, 32'h1);
    wr(4'h8, 32'h0);
    pulses(0, 2);
    rd(4'h8, d); check("R8 rewrite", d, 32'd2);

    // R10 feeding prevents any request
    cfg(3'd2, 3'd0, 16'd4);
    base = req_seen;
    for (int k = 0; k < 3; k++) begin
      pulses(1, 3);
      wr(4'h8, 32'h0);
    end
    pulses(1, 3);
    rd(4'h8, d); check("R10 count", d, 32'd3);
    check("R10 none", 32'(req_seen - base), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule